// File: doc/BRIEF.md
# Chained Descriptor Transmit DMA

This engine moves outgoing frames from memory to a byte stream. The host builds a ring of descriptors in a word-addressed memory. Each descriptor names one buffer and links to the descriptor after it. The host hands a descriptor over by setting its ownership bit, then writes the poll register. From that point the engine fetches the descriptor and reads the buffer one word at a time. It sends the bytes on a valid/ready byte interface toward a MAC. When the frame is done it writes the status word back with ownership cleared, then follows the link.

The engine keeps walking the ring as long as it finds descriptors it owns. When it fetches one the host still holds, it parks on that descriptor and raises a sticky suspended flag. The next poll write makes it fetch the same descriptor again. A soft-reset command drops whatever is in progress and points the engine back at the list base address.

Top module: `tx_dma_chain`

## Requirements
- R1: While reset is held and just after it is released, `tx_valid`, `mem_rd`, `mem_wr` and `tx_susp` are all low.
- R2: A descriptor takes four consecutive memory words starting at its word address D:
  - D+0 is status; bit 31 is the ownership bit, and 1 means the engine owns it.
  - D+1 is control; bits 12:0 hold the byte count, bit 28 marks the first segment and bit 29 the last segment.
  - D+2 is the buffer word address.
  - D+3 is the word address of the next descriptor.
  The engine goes to the descriptor named in D+3, wherever it lies, not to D+4.
- R3: For a descriptor with byte count N, exactly N bytes go out. They are taken from the buffer words in address order, and inside a word from bits 7:0 up to bits 31:24.
- R4: While `tx_valid` is high and `tx_ready` is low, the next cycle still has `tx_valid` high, with `tx_data`, `tx_first` and `tx_last` unchanged.
- R5: `tx_first` is high only on the first byte of a descriptor whose first-segment flag is set. `tx_last` is high only on the final byte of a descriptor whose last-segment flag is set.
- R6: After the final byte of a descriptor is accepted, the engine makes one write to that descriptor's status word. The write clears bit 31 and leaves every other status bit as it was fetched. A read and a write never share a cycle.
- R7: When a fetched status word has bit 31 clear:
  - no byte of that descriptor goes out;
  - `tx_susp` goes high and stays high until a poll write or a soft reset;
  - the engine makes no memory access while suspended.
- R8: The register port has three offsets. Offset 0 is the list base address. Offset 1 is control: bit 0 is run and bit 1 is soft reset. Offset 2 is poll demand. Setting run loads the current pointer from the base address but fetches nothing. Fetching begins only on a poll write while run is set, and after a suspension it restarts at the descriptor that stopped it.
- R9: A descriptor with byte count 0 sends no bytes. Its status word is still written back with bit 31 cleared, and the engine moves on to the linked descriptor.
- R10: A soft-reset write does four things: it ends any transfer within two cycles, clears `tx_susp`, clears run, and sets the current pointer to the list base. A later run and poll then start again from the base descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 base, 1 control, 2 poll) |
| reg_wdata | input | DW | Register write data |
| mem_rd | output | 1 | Memory read request; data returns one cycle later |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after `mem_rd` |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Byte value |
| tx_first | output | 1 | First byte of a first-segment descriptor |
| tx_last | output | 1 | Final byte of a last-segment descriptor |
| tx_susp | output | 1 | Sticky suspended flag |

## Verification
The assertions check these rules on every cycle:
- the output holds steady under backpressure;
- status write-backs always carry a cleared ownership bit;
- reads and writes never collide;
- the suspended flag stays set until a poll or a soft reset;
- no byte is offered while the engine is suspended.

The bench scenarios are needed for the rest:
- the engine follows links through a ring laid out out of address order;
- bytes come out in the right order with correct first and last markers;
- zero-length descriptors are skipped;
- the engine resumes at the descriptor that stopped it;
- after a soft reset it starts again at the base.

// File: rtl/tx_dma_pkg.sv
package tx_dma_pkg;

    typedef enum logic [3:0] {
        ST_WAIT,
        ST_RD_STS,
        ST_GET_STS,
        ST_GET_CTL,
        ST_GET_BUF,
        ST_GET_NXT,
        ST_GET_DAT,
        ST_SEND,
        ST_WB
    } dma_st_e;

    localparam logic [1:0] REG_BASE = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_POLL = 2'd2;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_SRST_BIT = 1;

endpackage

// File: rtl/tx_dma_regs.sv
module tx_dma_regs
    import tx_dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [AW-1:0] base,
    output logic          run,
    output logic          start,
    output logic          srst,
    output logic          poll
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic          run;
        logic          start;
        logic          srst;
        logic          poll;
    } regs_s;

    regs_s regs_d, regs_q;

    always_comb begin
        regs_d       = regs_q;
        regs_d.start = 1'b0;
        regs_d.srst  = 1'b0;
        regs_d.poll  = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                REG_BASE: regs_d.base = reg_wdata[AW-1:0];
                REG_CTRL: begin
                    regs_d.srst  = reg_wdata[CTRL_SRST_BIT];
                    regs_d.run   = reg_wdata[CTRL_RUN_BIT] & ~reg_wdata[CTRL_SRST_BIT];
                    regs_d.start = regs_d.run & ~regs_q.run;
                end
                REG_POLL: regs_d.poll = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign base  = regs_q.base;
    assign run   = regs_q.run;
    assign start = regs_q.start;
    assign srst  = regs_q.srst;
    assign poll  = regs_q.poll;

endmodule

// File: rtl/tx_dma_lane_mux.sv
module tx_dma_lane_mux #(
    parameter int DW     = 32,
    parameter int LANE_W = $clog2(DW/8)
) (
    input  logic [DW-1:0]     word,
    input  logic [LANE_W-1:0] lane,
    output logic [7:0]        byte_out
);

    localparam int LANES = DW / 8;

    logic [7:0] lane_bytes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word[8*g +: 8];
    end

    assign byte_out = lane_bytes[lane];

endmodule

// File: rtl/tx_dma_fsm.sv
module tx_dma_fsm
    import tx_dma_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int SZ_W      = 13,
    parameter int OWN_BIT   = 31,
    parameter int FIRST_BIT = 28,
    parameter int LAST_BIT  = 29,
    parameter int LANE_W    = $clog2(DW/8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start,
    input  logic              srst,
    input  logic              poll,
    input  logic [AW-1:0]     base,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              tx_ready,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [DW-1:0]     word,
    output logic [LANE_W-1:0] lane,
    output logic              tx_valid,
    output logic              tx_first,
    output logic              tx_last,
    output logic              susp
);

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(DW/8 - 1);
    localparam logic [DW-1:0]     OWN_MASK  = DW'(1) << OWN_BIT;
    localparam logic [SZ_W-1:0]   ONE_LEFT  = SZ_W'(1);

    typedef struct packed {
        dma_st_e           st;
        logic [AW-1:0]     cur;
        logic [AW-1:0]     nxt;
        logic [AW-1:0]     bptr;
        logic [DW-1:0]     sts;
        logic [DW-1:0]     word;
        logic [SZ_W-1:0]   rem;
        logic [LANE_W-1:0] lane;
        logic              head;
        logic              first_f;
        logic              last_f;
        logic              susp;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d     = fsm_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (fsm_q.st)
            ST_WAIT: begin
                if (run && poll) begin
                    fsm_d.st   = ST_RD_STS;
                    fsm_d.susp = 1'b0;
                end else if (start) begin
                    fsm_d.cur = base;
                end
            end
            ST_RD_STS: begin
                mem_rd   = 1'b1;
                mem_addr = fsm_q.cur;
                fsm_d.st = ST_GET_STS;
            end
            ST_GET_STS: begin
                fsm_d.sts = mem_rdata;
                if (mem_rdata[OWN_BIT]) begin
                    mem_rd   = 1'b1;
                    mem_addr = fsm_q.cur + AW'(1);
                    fsm_d.st = ST_GET_CTL;
                end else begin
                    fsm_d.st   = ST_WAIT;
                    fsm_d.susp = 1'b1;
                end
            end
            ST_GET_CTL: begin
                fsm_d.rem     = mem_rdata[SZ_W-1:0];
                fsm_d.first_f = mem_rdata[FIRST_BIT];
                fsm_d.last_f  = mem_rdata[LAST_BIT];
                fsm_d.head    = 1'b1;
                mem_rd        = 1'b1;
                mem_addr      = fsm_q.cur + AW'(2);
                fsm_d.st      = ST_GET_BUF;
            end
            ST_GET_BUF: begin
                fsm_d.bptr = mem_rdata[AW-1:0];
                mem_rd     = 1'b1;
                mem_addr   = fsm_q.cur + AW'(3);
                fsm_d.st   = ST_GET_NXT;
            end
            ST_GET_NXT: begin
                fsm_d.nxt  = mem_rdata[AW-1:0];
                fsm_d.lane = '0;
                if (fsm_q.rem == '0) begin
                    fsm_d.st = ST_WB;
                end else begin
                    mem_rd   = 1'b1;
                    mem_addr = fsm_q.bptr;
                    fsm_d.st = ST_GET_DAT;
                end
            end
            ST_GET_DAT: begin
                fsm_d.word = mem_rdata;
                fsm_d.st   = ST_SEND;
            end
            ST_SEND: begin
                if (tx_ready) begin
                    fsm_d.head = 1'b0;
                    fsm_d.rem  = fsm_q.rem - ONE_LEFT;
                    if (fsm_q.rem == ONE_LEFT) begin
                        fsm_d.st = ST_WB;
                    end else if (fsm_q.lane == LAST_LANE) begin
                        fsm_d.lane = '0;
                        fsm_d.bptr = fsm_q.bptr + AW'(1);
                        mem_rd     = 1'b1;
                        mem_addr   = fsm_q.bptr + AW'(1);
                        fsm_d.st   = ST_GET_DAT;
                    end else begin
                        fsm_d.lane = fsm_q.lane + LANE_W'(1);
                    end
                end
            end
            ST_WB: begin
                mem_wr    = 1'b1;
                mem_addr  = fsm_q.cur;
                mem_wdata = fsm_q.sts & ~OWN_MASK;
                fsm_d.cur = fsm_q.nxt;
                fsm_d.st  = run ? ST_RD_STS : ST_WAIT;
            end
            default: fsm_d.st = ST_WAIT;
        endcase

        if (srst) begin
            fsm_d     = '0;
            fsm_d.st  = ST_WAIT;
            fsm_d.cur = base;
            mem_rd    = 1'b0;
            mem_wr    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '0;
        else        fsm_q <= fsm_d;
    end

    assign word     = fsm_q.word;
    assign lane     = fsm_q.lane;
    assign tx_valid = (fsm_q.st == ST_SEND);
    assign tx_first = tx_valid & fsm_q.head & fsm_q.first_f;
    assign tx_last  = tx_valid & fsm_q.last_f & (fsm_q.rem == ONE_LEFT);
    assign susp     = fsm_q.susp;

endmodule

// File: rtl/tx_dma_chain.sv
module tx_dma_chain #(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int SZ_W      = 13,
    parameter int OWN_BIT   = 31,
    parameter int FIRST_BIT = 28,
    parameter int LAST_BIT  = 29
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_first,
    output logic          tx_last,
    output logic          tx_susp
);

    localparam int LANE_W = $clog2(DW/8);

    logic [AW-1:0]     base_p;
    logic              run_p;
    logic              start_p;
    logic              srst_p;
    logic              poll_p;
    logic [DW-1:0]     word_p;
    logic [LANE_W-1:0] lane_p;

    tx_dma_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .base      (base_p),
        .run       (run_p),
        .start     (start_p),
        .srst      (srst_p),
        .poll      (poll_p)
    );

    tx_dma_fsm #(
        .AW(AW), .DW(DW), .SZ_W(SZ_W), .OWN_BIT(OWN_BIT),
        .FIRST_BIT(FIRST_BIT), .LAST_BIT(LAST_BIT), .LANE_W(LANE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_p),
        .start     (start_p),
        .srst      (srst_p),
        .poll      (poll_p),
        .base      (base_p),
        .mem_rdata (mem_rdata),
        .tx_ready  (tx_ready),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .word      (word_p),
        .lane      (lane_p),
        .tx_valid  (tx_valid),
        .tx_first  (tx_first),
        .tx_last   (tx_last),
        .susp      (tx_susp)
    );

    tx_dma_lane_mux #(.DW(DW), .LANE_W(LANE_W)) u_mux (
        .word     (word_p),
        .lane     (lane_p),
        .byte_out (tx_data)
    );

endmodule

// File: rtl/tx_dma_chain_chk.sv
module tx_dma_chain_chk #(
    parameter int DW      = 32,
    parameter int OWN_BIT = 31
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_first,
    input logic          tx_last,
    input logic          tx_susp,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [DW-1:0] mem_wdata,
    input logic          poll,
    input logic          srst
);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !srst) |=>
            (tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last)));

    assert_own_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !mem_wdata[OWN_BIT]);

    assert_no_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_susp && !poll && !srst) |=> tx_susp);

    assert_quiet_susp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_susp |-> (!tx_valid && !mem_rd && !mem_wr));

    assert_srst_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!tx_susp && !tx_valid));

endmodule

bind tx_dma_chain tx_dma_chain_chk #(.DW(DW), .OWN_BIT(OWN_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_first  (tx_first),
    .tx_last   (tx_last),
    .tx_susp   (tx_susp),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .poll      (poll_p),
    .srst      (srst_p)
);

// File: tb/tx_dma_chain_test.sv
module tx_dma_chain_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_first, tx_last, tx_susp;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;

    always #5 clk = ~clk;

    tx_dma_chain uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last), .tx_susp(tx_susp)
    );

    logic [31:0] mem [0:1023];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rd_cnt = 0;
    int hold_seen = 0;
    int hold_bad = 0;
    bit hold_off = 1'b0;
    bit hold_pend = 1'b0;
    logic [7:0] hold_data;
    int ready_mode = 0;

    logic [9:0] cap_q [$];
    logic [9:0] exp_q [$];

    int dloc [4] = '{256, 384, 320, 448};
    int d_size [4];
    bit d_first [4];
    bit d_last [4];
    int d_salt [4];
    logic [31:0] d_sts [4];

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog: actual running expected finished");
            summary();
        end
    end

    always @(posedge clk) begin
        #1;
        if (ready_mode == 0)      tx_ready = ($urandom % 4) != 0;
        else if (ready_mode == 1) tx_ready = 1'b1;
        else                      tx_ready = 1'b0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend && !hold_off) begin
                hold_seen++;
                if (!(tx_valid && tx_data == hold_data)) hold_bad++;
            end
            hold_pend = tx_valid && !tx_ready;
            hold_data = tx_data;
            if (tx_valid && tx_ready) cap_q.push_back({tx_first, tx_last, tx_data});
            if (mem_rd) rd_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int k, int i, int salt);
        return 8'((k * 37 + i * 11 + salt) & 255);
    endfunction

    function automatic int bloc(int k);
        return 512 + 64 * k;
    endfunction

    task automatic setup_desc(int k, int size, bit f, bit l, bit own, int salt);
        d_size[k] = size; d_first[k] = f; d_last[k] = l; d_salt[k] = salt;
        d_sts[k] = 32'h0000_5A00 | 32'(salt & 255);
        mem[dloc[k]]     = d_sts[k] | (own ? 32'h8000_0000 : 32'h0);
        mem[dloc[k] + 1] = 32'(size) | (f ? 32'h1000_0000 : 32'h0) | (l ? 32'h2000_0000 : 32'h0);
        mem[dloc[k] + 2] = 32'(bloc(k));
        mem[dloc[k] + 3] = 32'(dloc[(k + 1) % 4]);
        for (int w = 0; w < (size + 3) / 4; w++)
            mem[bloc(k) + w] = {pat(k, 4*w+3, salt), pat(k, 4*w+2, salt),
                                pat(k, 4*w+1, salt), pat(k, 4*w, salt)};
    endtask

    task automatic expect_desc(int k);
        for (int i = 0; i < d_size[k]; i++)
            exp_q.push_back({d_first[k] && i == 0, d_last[k] && i == d_size[k] - 1,
                             pat(k, i, d_salt[k])});
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic wait_susp();
        int n = 0;
        while (!tx_susp && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_poll_wait();
        wr_reg(2'd2, 32'h0);
        repeat (4) @(posedge clk);
        wait_susp();
        @(negedge clk);
    endtask

    task automatic compare(input string req);
        int n;
        check(cap_q.size() == exp_q.size(), req, "byte count", cap_q.size(), exp_q.size());
        n = (cap_q.size() < exp_q.size()) ? cap_q.size() : exp_q.size();
        for (int i = 0; i < n; i++)
            check(cap_q[i] == exp_q[i], req, "byte {first,last,data}", cap_q[i], exp_q[i]);
        cap_q.delete();
        exp_q.delete();
    endtask

    task automatic check_wb(int k, input string req);
        check(mem[dloc[k]] == d_sts[k], req, "status write-back", mem[dloc[k]], d_sts[k]);
    endtask

    initial begin
        int r0;
        r0 = $urandom(32'd2024);
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!tx_valid && !mem_rd && !mem_wr && !tx_susp, "R1", "idle after reset",
              {tx_valid, mem_rd, mem_wr, tx_susp}, 0);

        // R8: run without poll fetches nothing
        setup_desc(0, 5, 1, 1, 1, 3);
        setup_desc(1, 0, 1, 1, 1, 9);
        setup_desc(2, 1 + ($urandom % 40), 1, 0, 1, 17);
        setup_desc(3, 8, 0, 1, 1, 41);
        wr_reg(2'd0, 32'd256);
        wr_reg(2'd1, 32'h1);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(rd_cnt == 0, "R8", "reads before poll", rd_cnt, 0);
        check(cap_q.size() == 0, "R8", "bytes before poll", cap_q.size(), 0);

        // R2 R3 R5: full ring walked out of address order, with a backpressure stretch
        for (int k = 0; k < 4; k++) expect_desc(k);
        wr_reg(2'd2, 32'h0);
        while (!tx_valid) @(negedge clk);
        ready_mode = 2;
        repeat (8) @(posedge clk);
        ready_mode = 0;
        wait_susp();
        @(negedge clk);
        compare("R2 R3 R5");
        for (int k = 0; k < 4; k++) check_wb(k, "R6");
        check_wb(1, "R9");
        check(tx_susp == 1'b1, "R7", "suspended flag", tx_susp, 1);
        r0 = rd_cnt;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(rd_cnt == r0 && tx_susp, "R7", "quiet while suspended", rd_cnt, r0);

        // R8: resume at the descriptor that stopped the engine
        setup_desc(0, 1 + ($urandom % 30), 1, 1, 1, 55);
        setup_desc(1, 12, 1, 1, 0, 66);
        setup_desc(2, 7, 1, 1, 1, 77);
        expect_desc(0);
        run_poll_wait();
        compare("R8");
        check(tx_susp == 1'b1, "R7", "suspend on host-owned", tx_susp, 1);
        check(mem[dloc[1]][31] == 1'b0 && mem[dloc[2]][31] == 1'b1, "R7",
              "untouched ownership", {mem[dloc[1]][31], mem[dloc[2]][31]}, 2'b01);
        setup_desc(1, 12, 1, 1, 1, 66);
        setup_desc(2, 7, 1, 1, 1, 77);
        expect_desc(1);
        expect_desc(2);
        run_poll_wait();
        compare("R8");

        // R10: soft reset clears the suspended flag
        check(tx_susp == 1'b1, "R10", "flag before soft reset", tx_susp, 1);
        wr_reg(2'd1, 32'h2);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(tx_susp == 1'b0, "R10", "flag after soft reset", tx_susp, 0);

        // R10: soft reset during a frame, then restart from base
        for (int k = 0; k < 4; k++) setup_desc(k, (k == 0) ? 40 : 6, 1, 1, 1, 100 + k);
        wr_reg(2'd1, 32'h1);
        wr_reg(2'd2, 32'h0);
        while (cap_q.size() < 3) @(negedge clk);
        hold_off = 1'b1;
        wr_reg(2'd1, 32'h2);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!tx_valid && !mem_rd, "R10", "transfer ended", {tx_valid, mem_rd}, 0);
        hold_off = 1'b0;
        cap_q.delete();
        for (int k = 0; k < 4; k++) setup_desc(k, 3 + 2 * k, 1, 1, 1, 120 + k);
        for (int k = 0; k < 4; k++) expect_desc(k);
        wr_reg(2'd1, 32'h1);
        run_poll_wait();
        compare("R10");

        // R3 R5 R9: random rounds
        for (int rnd = 0; rnd < 4; rnd++) begin
            for (int k = 0; k < 4; k++)
                setup_desc(k, $urandom % 64, 1'($urandom), 1'($urandom), 1, int'($urandom % 256));
            for (int k = 0; k < 4; k++) expect_desc(k);
            ready_mode = (rnd == 3) ? 1 : 0;
            run_poll_wait();
            compare("R3 R5 R9");
            for (int k = 0; k < 4; k++) check_wb(k, "R6");
        end
        ready_mode = 0;

        check(hold_bad == 0, "R4", "hold violations", hold_bad, 0);
        check(hold_seen > 0, "R4", "stall cycles seen", hold_seen, 1);
        summary();
    end

endmodule